// File: doc/BRIEF.md
# Four-Lane Double-Edge Transmit Capture and Serializer

This block takes four lanes of 10-bit characters that are already line-coded and turns each lane into a single-bit serial stream. A lane presents one character on every rising edge and one on every falling edge of its capture clock. The rising-edge character and the following falling-edge character form a pair. Each pair crosses into the reference-clock domain through a small FIFO with Gray-coded pointers. A serializer running on the reference clock then sends the pair out one bit for each cycle in which the bit-time enable is high. Bit 0 of the rising character goes first and bit 9 of the falling character goes last.

A mode pin chooses the capture clocks. Either lane 0's clock captures all four lanes, or each lane uses its own clock. The mode is taken in while reset is held and stays fixed until the next reset.

The character inputs form a source-synchronous stream. A character is implicitly valid on every edge of the capture clock, and there is no ready signal. The block cannot push back, so a lane's source must run at the character rate the serializer drains. Any excess is reported rather than stalled: a pair that arrives at a full FIFO is dropped and flagged as overflow. A pair that is due while the FIFO is empty is replaced by a repeat of the last pair and flagged as underflow.

Top module: `ddr_lane_serializer`

## Requirements
- R1: Each lane captures its 10-bit character on both the rising and the falling edge of its capture clock. The character taken at a rising edge is serialized before the character taken at the next falling edge.
- R2: Each 20-bit pair is sent least significant bit first: bit 0 to bit 9 of the rising character, then bit 0 to bit 9 of the falling character. `ser_out` changes only on a `clk_ref` edge at which `bit_en` is high, and it holds its value while `bit_en` is low.
- R3: With the mode latched at 1, all lanes are captured on `lane_clk[0]`, and `lane_clk[1..3]` have no effect. With the mode latched at 0, lane i is captured on `lane_clk[i]`.
- R4: `sync_mode` is sampled on `clk_ref` edges while `rst_n` is low. A change after reset release has no effect until the next reset.
- R5: Each lane's FIFO holds 8 pairs. When the capture-clock rate matches the drain rate, whatever the phase between them, every character comes out once, in order.
- R6: After reset, a lane's serial output stays low and its underflow flag stays clear until its FIFO has held 3 pairs.
- R7: If a lane's FIFO is empty when a new pair is due, the lane sends its previous pair again and sets `unf_flag[i]`. The flag stays set until reset.
- R8: A pair arriving at a full FIFO is discarded, and `ovf_flag[i]` is set and stays set until reset.
- R9: The lanes are independent. A stalled capture clock on one lane changes neither the stream nor the flags of any other lane.
- R10: While `rst_n` is low, `ser_out`, `ovf_flag` and `unf_flag` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Reference clock; serializer and FIFO read side |
| rst_n | input | 1 | Asynchronous active-low reset for all domains |
| bit_en | input | 1 | Serial bit-time enable, one bit sent per high cycle |
| sync_mode | input | 1 | 1: lane 0 clock captures all lanes; 0: per-lane clocks |
| lane_clk | input | 4 | Per-lane double-edge capture clocks |
| lane_data | input | 40 | Lane i character at bits [10i+9:10i] |
| ser_out | output | 4 | Serial stream per lane |
| ovf_flag | output | 4 | Sticky per-lane FIFO overflow |
| unf_flag | output | 4 | Sticky per-lane FIFO underflow |

## Verification
The bench builds the block with its defaults: four lanes, 10-bit characters, an 8-pair FIFO and a start level of 3. `bit_en` is held high, so the drain rate equals one 200 ns capture period per pair. Each character carries a marker bit, its lane number and a 7-bit running index. Every captured character can therefore be located in the serial stream and checked against the next index arithmetically, which exposes bit order, pair order, loss and duplication. Stalling single lane clocks in both modes, changing the mode pin after reset release, and holding `bit_en` low long enough to fill all eight entries bring the underflow, overflow and independence paths within reach.

// File: rtl/lane_ser_pkg.sv
package lane_ser_pkg;

  localparam int PTR_MAX_W = 8;

  typedef enum logic {
    MODE_INDEP = 1'b0,
    MODE_SYNC  = 1'b1
  } clk_mode_e;

  function automatic logic [PTR_MAX_W-1:0] gray_to_bin(input logic [PTR_MAX_W-1:0] g);
    logic [PTR_MAX_W-1:0] r;
    r[PTR_MAX_W-1] = g[PTR_MAX_W-1];
    for (int b = PTR_MAX_W - 2; b >= 0; b--) begin
      r[b] = r[b+1] ^ g[b];
    end
    return r;
  endfunction

endpackage

// File: rtl/ddr_char_capture.sv
module ddr_char_capture #(
  parameter int CHAR_W = 10
) (
  input  logic                cap_clk,
  input  logic                rst_n,
  input  logic [CHAR_W-1:0]   din,
  output logic                pair_vld,
  output logic [2*CHAR_W-1:0] pair_data
);

  logic [CHAR_W-1:0] rise_q;
  logic [CHAR_W-1:0] fall_q;
  logic              rise_seen;
  logic              fall_seen;

  always_ff @(posedge cap_clk or negedge rst_n) begin
    if (!rst_n) begin
      rise_q    <= '0;
      rise_seen <= 1'b0;
    end else begin
      rise_q    <= din;
      rise_seen <= 1'b1;
    end
  end

  always_ff @(negedge cap_clk or negedge rst_n) begin
    if (!rst_n) begin
      fall_q    <= '0;
      fall_seen <= 1'b0;
    end else begin
      fall_q    <= din;
      fall_seen <= rise_seen;
    end
  end

  // rising character in the low half: it leaves the serializer first
  assign pair_vld  = fall_seen;
  assign pair_data = {fall_q, rise_q};

  // R1
  pair_order_chk: assert property (@(posedge cap_clk) disable iff (!rst_n)
    fall_seen |-> rise_seen);

endmodule

// File: rtl/gray_cdc_fifo.sv
module gray_cdc_fifo
  import lane_ser_pkg::*;
#(
  parameter int DATA_W = 20,
  parameter int DEPTH  = 8
) (
  input  logic                   rst_n,
  input  logic                   wclk,
  input  logic                   wr_en,
  input  logic [DATA_W-1:0]      wdata,
  input  logic                   rclk,
  input  logic                   rd_en,
  output logic [DATA_W-1:0]      rdata,
  output logic                   empty,
  output logic [$clog2(DEPTH):0] level,
  output logic                   overflow
);

  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;
  localparam logic [PW-1:0] FULL_XOR = PW'(3) << (AW - 1);

  logic [DATA_W-1:0] mem [DEPTH];

  // write domain
  logic [PW-1:0] wbin, wbin_nxt, wgray;
  logic [PW-1:0] rg_s1, rg_s2;
  logic          full;
  logic          ovf_w;

  // read domain
  logic [PW-1:0] rbin, rbin_nxt, rgray;
  logic [PW-1:0] wg_s1, wg_s2;
  logic [PW-1:0] wbin_seen;
  logic          ovf_s1;

  assign wbin_nxt = wbin + PW'(1);
  assign full     = (wgray == (rg_s2 ^ FULL_XOR));

  always_ff @(posedge wclk) begin
    if (wr_en && !full) begin
      mem[wbin[AW-1:0]] <= wdata;
    end
  end

  always_ff @(posedge wclk or negedge rst_n) begin
    if (!rst_n) begin
      wbin  <= '0;
      wgray <= '0;
      rg_s1 <= '0;
      rg_s2 <= '0;
      ovf_w <= 1'b0;
    end else begin
      rg_s1 <= rgray;
      rg_s2 <= rg_s1;
      if (wr_en) begin
        if (full) begin
          ovf_w <= 1'b1;
        end else begin
          wbin  <= wbin_nxt;
          wgray <= wbin_nxt ^ (wbin_nxt >> 1);
        end
      end
    end
  end

  assign rbin_nxt  = rbin + PW'(1);
  assign empty     = (rgray == wg_s2);
  assign wbin_seen = PW'(gray_to_bin(PTR_MAX_W'(wg_s2)));
  assign level     = wbin_seen - rbin;
  assign rdata     = mem[rbin[AW-1:0]];

  always_ff @(posedge rclk or negedge rst_n) begin
    if (!rst_n) begin
      rbin     <= '0;
      rgray    <= '0;
      wg_s1    <= '0;
      wg_s2    <= '0;
      ovf_s1   <= 1'b0;
      overflow <= 1'b0;
    end else begin
      wg_s1    <= wgray;
      wg_s2    <= wg_s1;
      ovf_s1   <= ovf_w;
      overflow <= ovf_s1;
      if (rd_en && !empty) begin
        rbin  <= rbin_nxt;
        rgray <= rbin_nxt ^ (rbin_nxt >> 1);
      end
    end
  end

  // R5
  pop_when_empty_chk: assert property (@(posedge rclk) disable iff (!rst_n)
    rd_en |-> !empty);

  // R5
  level_bound_chk: assert property (@(posedge rclk) disable iff (!rst_n)
    level <= PW'(DEPTH));

  // R5
  gray_step_chk: assert property (@(posedge rclk) disable iff (!rst_n)
    $countones(wg_s1 ^ $past(wg_s1)) <= 1);

  // R8
  ovf_sticky_chk: assert property (@(posedge wclk) disable iff (!rst_n)
    ovf_w |=> ovf_w);

endmodule

// File: rtl/lane_serializer.sv
module lane_serializer #(
  parameter int PAIR_W      = 20,
  parameter int LVL_W       = 4,
  parameter int START_LEVEL = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_en,
  input  logic              fifo_empty,
  input  logic [LVL_W-1:0]  fifo_level,
  input  logic [PAIR_W-1:0] fifo_data,
  output logic              pop,
  output logic              ser_out,
  output logic              underflow
);

  localparam int CNT_W = $clog2(PAIR_W);

  logic [CNT_W-1:0]  bit_idx;
  logic [PAIR_W-1:0] cur;
  logic [PAIR_W-1:0] next_word;
  logic              started;
  logic              at_boundary;

  assign at_boundary = bit_en && started && (bit_idx == '0);
  assign pop         = at_boundary && !fifo_empty;
  assign next_word   = pop ? fifo_data : cur;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      started   <= 1'b0;
      bit_idx   <= '0;
      cur       <= '0;
      ser_out   <= 1'b0;
      underflow <= 1'b0;
    end else begin
      if (!started && fifo_level >= LVL_W'(START_LEVEL)) begin
        started <= 1'b1;
      end
      if (bit_en && started) begin
        if (bit_idx == '0) begin
          cur     <= next_word;
          ser_out <= next_word[0];
          if (fifo_empty) begin
            underflow <= 1'b1;
          end
        end else begin
          ser_out <= cur[bit_idx];
        end
        bit_idx <= (bit_idx == CNT_W'(PAIR_W - 1)) ? '0 : bit_idx + CNT_W'(1);
      end
    end
  end

  // R2
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en |=> $stable(ser_out));

  // R7
  unf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    underflow |=> underflow);

  // R6
  unf_needs_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(underflow) |-> $past(started) && $past(bit_en));

endmodule

// File: rtl/ddr_lane_serializer.sv
module ddr_lane_serializer
  import lane_ser_pkg::*;
#(
  parameter int LANES       = 4,
  parameter int CHAR_W      = 10,
  parameter int FIFO_DEPTH  = 8,
  parameter int START_LEVEL = 3
) (
  input  logic                    clk_ref,
  input  logic                    rst_n,
  input  logic                    bit_en,
  input  logic                    sync_mode,
  input  logic [LANES-1:0]        lane_clk,
  input  logic [LANES*CHAR_W-1:0] lane_data,
  output logic [LANES-1:0]        ser_out,
  output logic [LANES-1:0]        ovf_flag,
  output logic [LANES-1:0]        unf_flag
);

  localparam int PAIR_W = 2 * CHAR_W;
  localparam int LVL_W  = $clog2(FIFO_DEPTH) + 1;

  clk_mode_e mode_q;

  // latched only while reset is held; static afterwards
  always_ff @(posedge clk_ref) begin
    if (!rst_n) begin
      mode_q <= clk_mode_e'(sync_mode);
    end
  end

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic              cap_clk;
    logic              pair_vld;
    logic [PAIR_W-1:0] pair_data;
    logic [PAIR_W-1:0] rd_data;
    logic              empty;
    logic [LVL_W-1:0]  level;
    logic              pop;

    assign cap_clk = (mode_q == MODE_SYNC) ? lane_clk[0] : lane_clk[i];

    ddr_char_capture #(.CHAR_W(CHAR_W)) u_cap (
      .cap_clk  (cap_clk),
      .rst_n    (rst_n),
      .din      (lane_data[i*CHAR_W +: CHAR_W]),
      .pair_vld (pair_vld),
      .pair_data(pair_data)
    );

    gray_cdc_fifo #(.DATA_W(PAIR_W), .DEPTH(FIFO_DEPTH)) u_fifo (
      .rst_n   (rst_n),
      .wclk    (cap_clk),
      .wr_en   (pair_vld),
      .wdata   (pair_data),
      .rclk    (clk_ref),
      .rd_en   (pop),
      .rdata   (rd_data),
      .empty   (empty),
      .level   (level),
      .overflow(ovf_flag[i])
    );

    lane_serializer #(.PAIR_W(PAIR_W), .LVL_W(LVL_W), .START_LEVEL(START_LEVEL)) u_ser (
      .clk       (clk_ref),
      .rst_n     (rst_n),
      .bit_en    (bit_en),
      .fifo_empty(empty),
      .fifo_level(level),
      .fifo_data (rd_data),
      .pop       (pop),
      .ser_out   (ser_out[i]),
      .underflow (unf_flag[i])
    );
  end

  // R4
  mode_stable_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
    1'b1 |=> $stable(mode_q));

endmodule

// File: tb/tb_ddr_lane_serializer.sv
module tb_ddr_lane_serializer;

  localparam int LANES = 4;
  localparam int CW    = 10;
  localparam int NBITS = 640;

  logic                 clk_ref = 1'b0;
  logic                 rst_n   = 1'b0;
  logic                 bit_en  = 1'b1;
  logic                 sync_mode = 1'b0;
  logic                 tb_mode = 1'b0;
  logic                 restart = 1'b0;
  logic [LANES-1:0]     run_en  = '0;
  logic [LANES-1:0]     lane_clk;
  logic [LANES*CW-1:0]  lane_data;
  logic [LANES-1:0]     ser_out, ovf_flag, unf_flag;

  int vectors = 0;
  int errors  = 0;
  bit done    = 1'b0;
  bit bits [LANES][NBITS];

  always #5 clk_ref = ~clk_ref;

  ddr_lane_serializer dut (
    .clk_ref  (clk_ref),
    .rst_n    (rst_n),
    .bit_en   (bit_en),
    .sync_mode(sync_mode),
    .lane_clk (lane_clk),
    .lane_data(lane_data),
    .ser_out  (ser_out),
    .ovf_flag (ovf_flag),
    .unf_flag (unf_flag)
  );

  function automatic logic [CW-1:0] chr(input int ln, input int k);
    return {1'b1, 2'(ln), 7'(k)};
  endfunction

  for (genvar i = 0; i < LANES; i++) begin : g_src
    logic          lc = 1'b0;
    logic [CW-1:0] d  = '0;
    wire           src = tb_mode ? lane_clk[0] : lane_clk[i];
    assign lane_clk[i]         = lc;
    assign lane_data[i*CW +: CW] = d;

    initial begin
      forever begin
        wait (run_en[i] == 1'b1);
        #(3 + 23 * i);
        while (run_en[i]) begin
          lc = 1'b1; #100;
          lc = 1'b0; #100;
        end
      end
    end

    initial begin
      int k;
      k = 0;
      d = chr(i, 0);
      forever begin
        @(posedge src or negedge src or posedge restart);
        if (restart) begin
          k = 0;
          d = chr(i, 0);
        end else begin
          #50;
          k++;
          d = chr(i, k);
        end
      end
    end
  end

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req, input string what);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic collect(input int n);
    for (int s = 0; s < n; s++) begin
      @(negedge clk_ref);
      for (int l = 0; l < LANES; l++) bits[l][s] = ser_out[l];
    end
  endtask

  function automatic logic [CW-1:0] getc(input int ln, input int p);
    logic [CW-1:0] c;
    for (int b = 0; b < CW; b++) c[b] = bits[ln][p+b];
    return c;
  endfunction

  // R1 R2: pair starts with an even-index rising character, LSB first
  task automatic check_stream(input int ln, input int n, input string req);
    int off;
    int base;
    logic [CW-1:0] c0, c1;
    off = -1;
    for (int o = 0; o < 2 * CW && off < 0; o++) begin
      c0 = getc(ln, o);
      c1 = getc(ln, o + CW);
      if (c0 == chr(ln, int'(c0[6:0])) && !c0[0] && c1 == chr(ln, int'(c0[6:0]) + 1)) off = o;
    end
    vectors++;
    if (off < 0) begin
      errors++;
      $display("FAIL %s lane %0d alignment: actual none expected lane-tagged pair", req, ln);
      return;
    end
    base = int'(getc(ln, off) & 10'h07f);
    for (int j = 0; off + CW * (j + 1) <= n; j++) begin
      chk(32'(getc(ln, off + CW * j)), 32'(chr(ln, base + j)), req, $sformatf("lane %0d char %0d", ln, j));
    end
  endtask

  task automatic start_run(input logic mode);
    run_en = '0;
    #600;
    rst_n     = 1'b0;
    sync_mode = mode;
    tb_mode   = mode;
    bit_en    = 1'b1;
    restart   = 1'b1;
    #1 restart = 1'b0;
    repeat (4) @(posedge clk_ref);
    @(negedge clk_ref);
    chk(32'(ser_out), 0, "R10", "ser_out in reset");
    chk(32'(ovf_flag), 0, "R10", "ovf in reset");
    chk(32'(unf_flag), 0, "R10", "unf in reset");
    rst_n = 1'b1;
  endtask

  initial begin
    logic [LANES-1:0] held;
    int same;

    // independent mode, no capture clocks yet: idle output
    start_run(1'b0);
    repeat (100) @(negedge clk_ref);
    chk(32'(ser_out), 0, "R6", "idle before start level");
    chk(32'(unf_flag), 0, "R6", "no underflow before start");

    // independent mode, staggered lane phases
    run_en = 4'hf;
    #3000;
    collect(600);
    for (int l = 0; l < LANES; l++) check_stream(l, 600, "R5");
    chk(32'(ovf_flag), 0, "R5", "ovf clean run indep");
    chk(32'(unf_flag), 0, "R5", "unf clean run indep");

    // R4: pin change after release ignored; R7/R9: stall lane 2 only
    sync_mode = 1'b1;
    run_en[2] = 1'b0;
    #2000;
    collect(600);
    chk(32'(unf_flag), 32'h4, "R4 R9", "only stalled lane underflows");
    chk(32'(ovf_flag), 0, "R9", "ovf with lane 2 stalled");
    check_stream(0, 600, "R9");
    check_stream(1, 600, "R9");
    check_stream(3, 600, "R9");
    same = 1;
    for (int j = 0; j < 2 * CW; j++) if (bits[2][j] != bits[2][j + 2 * CW]) same = 0;
    chk(32'(same), 1, "R7", "stalled lane repeats last pair");
    chk(32'(getc(2, 0) != 0 || getc(2, CW) != 0), 1, "R7", "repeated pair not idle");

    // R3: shared clock, other lane clocks ignored
    start_run(1'b1);
    run_en = 4'hf;
    #3000;
    collect(600);
    for (int l = 0; l < LANES; l++) check_stream(l, 600, "R3");
    chk(32'(unf_flag | ovf_flag), 0, "R3", "flags shared clock");
    run_en = 4'b0011;
    #2000;
    collect(600);
    for (int l = 0; l < LANES; l++) check_stream(l, 600, "R3");
    chk(32'(unf_flag), 0, "R3", "unf with lanes 2,3 clocks stopped");
    chk(32'(ovf_flag), 0, "R3", "ovf with lanes 2,3 clocks stopped");

    // R8 and R2 hold: stop draining
    start_run(1'b0);
    run_en = 4'hf;
    #3000;
    @(negedge clk_ref);
    bit_en = 1'b0;
    @(negedge clk_ref);
    held = ser_out;
    #3000;
    @(negedge clk_ref);
    chk(32'(ovf_flag), 32'hf, "R8", "overflow all lanes");
    chk(32'(unf_flag), 0, "R8", "no underflow while stalled");
    chk(32'(ser_out), 32'(held), "R2", "ser_out holds with bit_en low");
    bit_en = 1'b1;
    run_en = '0;

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

endmodule